// File: doc/BRIEF.md
# I2C Dual-Wiper Register Target

This block is an I2C target that owns two wiper setting registers and a small byte-wide nonvolatile store. The nonvolatile store is modelled as an inferred RAM; the storage timing is modelled by a busy timer. The block runs on a fast system clock. It brings SCL and SDA through two-flop synchronizers, detects START and STOP, and drives SDA only through an active-high pull-down enable.

A transaction begins with the 7-bit device address. Its upper five bits are a parameter, and its lower two bits must equal the `strap_i` pins, so four of these targets can share one bus. A write carries an instruction byte next. That byte either sets a register pointer or fires a quick command. The pointer consists of a bank flag and a 5-bit address. Any data bytes that follow are written at the pointer, which then steps on. A read with no instruction byte streams data from the current pointer. A random read is an instruction-only write, then a repeated START, then a read. After the nonvolatile store is written, the target refuses its own address for a fixed number of cycles. A host finds out when the store is ready by polling with the address.

Top module: `i2cw_target`

## Requirements
- R1: After reset both wiper outputs hold midscale (bit WIPER_W-1 set, all other bits clear; 0x80 for 8 bits), and SDA is released.
- R2: The address byte is {ADDR_HI[4:0], strap_i[1:0], R/W}, with R/W = 1 for a read. The target ACKs by pulling SDA low in the ninth clock. On a mismatch it never drives SDA and changes no register until the next START.
- R3: In the instruction byte, bit 7 = 1 selects a quick command and bit 7 = 0 selects register access. Bit 6 = 1 selects the nonvolatile bank and bit 6 = 0 selects the wiper bank. Bits 4..0 are the register address. Wiper channel A is at address 1 and channel B at address 3. A data byte written there updates that output.
- R4: After each data byte written or read, the pointer advances by 2 in the wiper bank and by 1 in the nonvolatile bank. A write starting at wiper address 1 therefore fills channel A and then channel B.
- R5: Wiper-bank addresses other than 1 and 3 are ACKed on write, their data is discarded, and they read as 0x00.
- R6: A read that is not preceded by an instruction byte starts at the pointer left by the previous access.
- R7: An instruction-only write followed by a repeated START and a read returns data from the newly selected address.
- R8: A write to the nonvolatile bank, or a store command, starts a busy period of BUSY_CYCLES cycles at the following STOP. During that period the target does not ACK its own address. Once the period ends it ACKs the address again.
- R9: Quick command code 2 (bits 6..3 = 0010) copies the wiper at bits 2..0 (1 or 3) into the nonvolatile location with the same index. Code 1 (0001) copies that nonvolatile location back into the wiper.
- R10: The target changes its SDA drive only while SCL is low.
- R11: When the host answers a read byte with NACK, the target releases SDA and stays silent until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 2 | Low two bits of the device address |
| sda_oe_o | output | 1 | When high, pull SDA low |
| wiper_a_o | output | WIPER_W | Channel A wiper setting (address 1) |
| wiper_b_o | output | WIPER_W | Channel B wiper setting (address 3) |

## Verification
The assertions assume a bus host that holds each SCL phase for several system clocks. Under that assumption, a wiper update triggered by a data byte or by a restore command completes while the state machine is still in the instruction or data-write state. The assertions also assume the host never raises START or STOP while the target is driving SDA. The bench bit-bangs SCL with ten-cycle half periods. It moves its own SDA only while SCL is low, except at deliberate START and STOP points, and it releases SDA during every ACK slot the target owns. The strap pins are changed only between transactions.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } st_e;

  localparam logic [3:0] CMD_RESTORE = 4'd1;
  localparam logic [3:0] CMD_STORE   = 4'd2;

  // Wiper channels sit on odd addresses, so that bank steps by two.
  function automatic logic [4:0] step_ptr(input logic nv_bank, input logic [4:0] p);
    return nv_bank ? p + 5'd1 : p + 5'd2;
  endfunction

  function automatic logic is_channel(input logic [2:0] a);
    return (a == 3'd1) || (a == 3'd3);
  endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign bus_start =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign bus_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2cw_busy.sv
module i2cw_busy #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start_i)     cnt <= CW'(CYCLES);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs
  import i2cw_pkg::*;
#(
  parameter int WIPER_W  = 8,
  parameter int NV_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic               wr_bank_i,
  input  logic [4:0]         wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               rd_bank_i,
  input  logic [4:0]         rd_addr_i,
  output logic [7:0]         rd_data_o,
  input  logic               cmd_restore_i,
  input  logic               cmd_store_i,
  input  logic [2:0]         cmd_addr_i,
  output logic [WIPER_W-1:0] wiper_a_o,
  output logic [WIPER_W-1:0] wiper_b_o
);
  localparam int                 NV_AW  = $clog2(NV_DEPTH);
  localparam logic [5:0]         NV_LIM = 6'(NV_DEPTH);
  localparam logic [WIPER_W-1:0] MID    = WIPER_W'(1) << (WIPER_W - 1);

  logic [7:0]       nv_mem [NV_DEPTH];
  logic [7:0]       nv_q;
  logic             nv_we;
  logic [NV_AW-1:0] nv_wa, nv_ra;
  logic [7:0]       nv_wd;
  logic             rs_pend, rs_pend2;
  logic [2:0]       rs_addr;
  logic             rd_bank_q;
  logic [4:0]       rd_addr_q;
  logic [7:0]       store_val;
  logic             wr_nv_hit;

  // Two channels, each at odd register address 2*c+1.
  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam logic [4:0] CH_ADDR = 5'(2 * c + 1);
    logic [WIPER_W-1:0] val;
    always_ff @(posedge clk) begin
      if (rst)
        val <= MID;
      else if (wr_en_i && !wr_bank_i && wr_addr_i == CH_ADDR)
        val <= wr_data_i[WIPER_W-1:0];
      else if (rs_pend2 && rs_addr == CH_ADDR[2:0])
        val <= nv_q[WIPER_W-1:0];
    end
  end

  assign wiper_a_o = g_ch[0].val;
  assign wiper_b_o = g_ch[1].val;

  assign store_val = (cmd_addr_i == 3'd1) ? 8'(g_ch[0].val) : 8'(g_ch[1].val);
  assign wr_nv_hit = ({1'b0, wr_addr_i} < NV_LIM);
  assign nv_we     = (wr_en_i && wr_bank_i && wr_nv_hit) ||
                     (cmd_store_i && is_channel(cmd_addr_i));
  assign nv_wa     = cmd_store_i ? NV_AW'(cmd_addr_i) : wr_addr_i[NV_AW-1:0];
  assign nv_wd     = cmd_store_i ? store_val : wr_data_i;
  assign nv_ra     = rs_pend ? NV_AW'(rs_addr) : rd_addr_i[NV_AW-1:0];

  // Inferable single-port-write, registered-read RAM.
  always_ff @(posedge clk) begin
    if (nv_we) nv_mem[nv_wa] <= nv_wd;
    nv_q <= nv_mem[nv_ra];
  end

  // Restore: one cycle to steer the read port, one to read, then load.
  always_ff @(posedge clk) begin
    if (rst) begin
      rs_pend  <= 1'b0;
      rs_pend2 <= 1'b0;
      rs_addr  <= '0;
    end else begin
      rs_pend  <= cmd_restore_i && is_channel(cmd_addr_i);
      rs_pend2 <= rs_pend;
      if (cmd_restore_i) rs_addr <= cmd_addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bank_q <= 1'b0;
      rd_addr_q <= '0;
      rd_data_o <= '0;
    end else begin
      rd_bank_q <= rd_bank_i;
      rd_addr_q <= rd_addr_i;
      if (rd_bank_q)
        rd_data_o <= ({1'b0, rd_addr_q} < NV_LIM) ? nv_q : 8'h00;
      else if (rd_addr_q == 5'd1)
        rd_data_o <= 8'(g_ch[0].val);
      else if (rd_addr_q == 5'd3)
        rd_data_o <= 8'(g_ch[1].val);
      else
        rd_data_o <= 8'h00;
    end
  end
endmodule

// File: rtl/i2cw_target.sv
module i2cw_target
  import i2cw_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b01011,
  parameter int         WIPER_W     = 8,
  parameter int         NV_DEPTH    = 16,
  parameter int         BUSY_CYCLES = 2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         strap_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper_a_o,
  output logic [WIPER_W-1:0] wiper_b_o
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, bus_start, bus_stop;
  logic busy, busy_start;

  st_e        st;
  logic       in_ack;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, txd;
  logic [4:0] ptr;
  logic       ptr_bank;
  logic       rd_mode, cmd_mode, nv_dirty, mack;
  logic       addr_hit;
  logic       st_idle, st_xfer;

  logic       wr_en_q, wr_bank_q;
  logic [4:0] wr_addr_q;
  logic [7:0] wr_data_q;
  logic       cmd_restore_q, cmd_store_q;
  logic [2:0] cmd_addr_q;
  logic [7:0] rd_data;

  i2cw_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o ({scl_s, sda_s})
  );

  i2cw_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2cw_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk     (clk),
    .rst     (rst),
    .start_i (busy_start),
    .busy_o  (busy)
  );

  i2cw_regs #(.WIPER_W(WIPER_W), .NV_DEPTH(NV_DEPTH)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .wr_en_i       (wr_en_q),
    .wr_bank_i     (wr_bank_q),
    .wr_addr_i     (wr_addr_q),
    .wr_data_i     (wr_data_q),
    .rd_bank_i     (ptr_bank),
    .rd_addr_i     (ptr),
    .rd_data_o     (rd_data),
    .cmd_restore_i (cmd_restore_q),
    .cmd_store_i   (cmd_store_q),
    .cmd_addr_i    (cmd_addr_q),
    .wiper_a_o     (wiper_a_o),
    .wiper_b_o     (wiper_b_o)
  );

  assign addr_hit = (shreg[7:1] == {ADDR_HI, strap_i}) && !busy;
  assign st_idle  = (st == ST_IDLE);
  assign st_xfer  = (st == ST_INSTR) || (st == ST_WDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      in_ack        <= 1'b0;
      bit_cnt       <= '0;
      shreg         <= '0;
      txd           <= '0;
      ptr           <= '0;
      ptr_bank      <= 1'b0;
      rd_mode       <= 1'b0;
      cmd_mode      <= 1'b0;
      nv_dirty      <= 1'b0;
      mack          <= 1'b1;
      sda_oe_o      <= 1'b0;
      busy_start    <= 1'b0;
      wr_en_q       <= 1'b0;
      wr_bank_q     <= 1'b0;
      wr_addr_q     <= '0;
      wr_data_q     <= '0;
      cmd_restore_q <= 1'b0;
      cmd_store_q   <= 1'b0;
      cmd_addr_q    <= '0;
    end else begin
      wr_en_q       <= 1'b0;
      cmd_restore_q <= 1'b0;
      cmd_store_q   <= 1'b0;
      busy_start    <= 1'b0;
      if (bus_start) begin
        st       <= ST_ADDR;
        in_ack   <= 1'b0;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (bus_stop) begin
        st       <= ST_IDLE;
        in_ack   <= 1'b0;
        sda_oe_o <= 1'b0;
        if (nv_dirty) begin
          busy_start <= 1'b1;
          nv_dirty   <= 1'b0;
        end
      end else begin
        case (st)
          ST_ADDR, ST_INSTR, ST_WDATA: begin
            if (!in_ack) begin
              if (scl_rise) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + 4'd1;
              end else if (scl_fall && bit_cnt == LAST_BIT) begin
                in_ack  <= 1'b1;
                bit_cnt <= '0;
                if (st == ST_ADDR) begin
                  if (addr_hit) begin
                    sda_oe_o <= 1'b1;
                    rd_mode  <= shreg[0];
                  end else begin
                    st <= ST_IGNORE;
                  end
                end else if (st == ST_INSTR) begin
                  sda_oe_o <= 1'b1;
                  cmd_mode <= shreg[7];
                  if (shreg[7]) begin
                    cmd_addr_q    <= shreg[2:0];
                    cmd_restore_q <= (shreg[6:3] == CMD_RESTORE);
                    cmd_store_q   <= (shreg[6:3] == CMD_STORE);
                    if (shreg[6:3] == CMD_STORE) nv_dirty <= 1'b1;
                  end else begin
                    ptr_bank <= shreg[6];
                    ptr      <= shreg[4:0];
                  end
                end else begin
                  sda_oe_o  <= 1'b1;
                  wr_en_q   <= 1'b1;
                  wr_bank_q <= ptr_bank;
                  wr_addr_q <= ptr;
                  wr_data_q <= shreg;
                  ptr       <= step_ptr(ptr_bank, ptr);
                  if (ptr_bank) nv_dirty <= 1'b1;
                end
              end
            end else if (scl_fall) begin
              in_ack   <= 1'b0;
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
              if (st == ST_ADDR) begin
                if (rd_mode) begin
                  st       <= ST_RDATA;
                  txd      <= rd_data;
                  sda_oe_o <= ~rd_data[7];
                end else begin
                  st <= ST_INSTR;
                end
              end else if (st == ST_INSTR) begin
                st <= cmd_mode ? ST_IGNORE : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (!in_ack) begin
              if (scl_rise) begin
                bit_cnt <= bit_cnt + 4'd1;
              end else if (scl_fall) begin
                if (bit_cnt == LAST_BIT) begin
                  sda_oe_o <= 1'b0;
                  in_ack   <= 1'b1;
                  ptr      <= step_ptr(ptr_bank, ptr);
                end else begin
                  txd      <= {txd[6:0], 1'b0};
                  sda_oe_o <= ~txd[6];
                end
              end
            end else begin
              if (scl_rise) begin
                mack <= sda_s;
              end else if (scl_fall) begin
                in_ack  <= 1'b0;
                bit_cnt <= '0;
                if (!mack) begin
                  txd      <= rd_data;
                  sda_oe_o <= ~rd_data[7];
                end else begin
                  st <= ST_IGNORE;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cw_target_chk.sv
module i2cw_target_chk #(
  parameter int WIPER_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_s,
  input logic               sda_oe,
  input logic               busy,
  input logic               st_idle,
  input logic               st_xfer,
  input logic [WIPER_W-1:0] wiper_a,
  input logic [WIPER_W-1:0] wiper_b
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s); // R10

  AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe); // R8

  AST_SILENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    st_idle |-> !sda_oe); // R2

  AST_WIPER_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wiper_a) || !$stable(wiper_b)) |-> st_xfer); // R3
endmodule

bind i2cw_target i2cw_target_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_s   (scl_s),
  .sda_oe  (sda_oe_o),
  .busy    (busy),
  .st_idle (st_idle),
  .st_xfer (st_xfer),
  .wiper_a (wiper_a_o),
  .wiper_b (wiper_b_o)
);

// File: tb/test_i2cw_target.sv
module test_i2cw_target;
  localparam int HP = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       sda_oe;
  logic [7:0] wiper_a, wiper_b;
  logic       sda;
  logic       prev_oe = 1'b0;
  int         checks = 0;
  int         errors = 0;
  int         viol = 0;

  assign sda = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2cw_target #(.BUSY_CYCLES(600)) i_i2cw_target (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl),
    .sda_i     (sda),
    .strap_i   (strap),
    .sda_oe_o  (sda_oe),
    .wiper_a_o (wiper_a),
    .wiper_b_o (wiper_b)
  );

  // R10 monitor: SDA drive must not move while SCL is high.
  always @(posedge clk) begin
    if (!rst && scl && (sda_oe != prev_oe)) viol++;
    prev_oe <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HP);
    scl = 1'b1;   tick(HP);
    m_sda = 1'b0; tick(HP);
    scl = 1'b0;   tick(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP);
    scl = 1'b1;   tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(HP);
      scl = 1'b1;   tick(HP);
      scl = 1'b0;   tick(2);
    end
    m_sda = 1'b1; tick(HP);
    scl = 1'b1;   tick(HP / 2);
    ack = !sda;   tick(HP / 2);
    scl = 1'b0;   tick(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nak);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP);
      scl = 1'b1; tick(HP / 2);
      b[i] = sda; tick(HP / 2);
      scl = 1'b0;
    end
    tick(2);
    m_sda = nak; tick(HP);
    scl = 1'b1;  tick(HP);
    scl = 1'b0;  tick(2);
    m_sda = 1'b1;
  endtask

  task automatic wait_ready(output int polls, output logic ok);
    logic a;
    polls = 0;
    ok = 1'b0;
    for (int n = 0; n < 20; n++) begin
      bus_start();
      send_byte(8'h5A, a);
      bus_stop();
      polls++;
      if (a) begin ok = 1'b1; break; end
      tick(20);
    end
  endtask

  task automatic t_reset();
    chk("R1 wiper A", wiper_a, 8'h80);
    chk("R1 wiper B", wiper_b, 8'h80);
    chk("R1 sda released", sda_oe, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'h5C, a);
    chk("R2 foreign address NACK", a, 0);
    send_byte(8'h01, a);
    send_byte(8'h99, a);
    bus_stop();
    chk("R2 no write on mismatch", wiper_a, 8'h80);
  endtask

  task automatic t_single();
    logic a0, a1, a2;
    bus_start();
    send_byte(8'h5A, a0);
    send_byte(8'h01, a1);
    send_byte(8'h3C, a2);
    bus_stop();
    chk("R2 own address ACK", a0, 1);
    chk("R3 data ACK", a2, 1);
    chk("R3 wiper A written", wiper_a, 8'h3C);
    chk("R3 wiper B untouched", wiper_b, 8'h80);
  endtask

  task automatic t_consec();
    logic a;
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h01, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    bus_stop();
    chk("R4 first byte to A", wiper_a, 8'h11);
    chk("R4 second byte to B", wiper_b, 8'h22);
  endtask

  task automatic t_unimpl();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h02, a);
    send_byte(8'h55, a);
    bus_stop();
    chk("R5 unimplemented write ACK", a, 1);
    chk("R5 A unchanged", wiper_a, 8'h11);
    chk("R5 B unchanged", wiper_b, 8'h22);
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h02, a);
    bus_start();
    send_byte(8'h5B, a);
    recv_byte(d, 1'b1);
    bus_stop();
    chk("R5 unimplemented reads zero", d, 8'h00);
  endtask

  task automatic t_random();
    logic a;
    logic [7:0] d0, d1;
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h03, a);
    bus_start();
    send_byte(8'h5B, a);
    chk("R7 read address ACK", a, 1);
    recv_byte(d0, 1'b0);
    recv_byte(d1, 1'b1);
    chk("R11 released after host NACK", sda_oe, 0);
    bus_stop();
    chk("R7 random read B", d0, 8'h22);
    chk("R4 read step 3 to 5", d1, 8'h00);
  endtask

  task automatic t_current();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h01, a);
    bus_start();
    send_byte(8'h5B, a);
    recv_byte(d, 1'b1);
    bus_stop();
    chk("R7 random read A", d, 8'h11);
    bus_start();
    send_byte(8'h5B, a);
    recv_byte(d, 1'b1);
    bus_stop();
    chk("R6 current read continues at B", d, 8'h22);
  endtask

  task automatic t_nv();
    logic a;
    logic ok;
    int polls;
    logic [7:0] d0, d1;
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h45, a);
    send_byte(8'hA5, a);
    send_byte(8'h5A, a);
    bus_stop();
    bus_start();
    send_byte(8'h5A, a);
    bus_stop();
    chk("R8 busy NACK", a, 0);
    wait_ready(polls, ok);
    chk("R8 ready ACK", ok, 1);
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h45, a);
    bus_start();
    send_byte(8'h5B, a);
    recv_byte(d0, 1'b0);
    recv_byte(d1, 1'b1);
    bus_stop();
    chk("R3 nonvolatile byte", d0, 8'hA5);
    chk("R4 nonvolatile step by one", d1, 8'h5A);
  endtask

  task automatic t_cmd();
    logic a;
    logic ok;
    int polls;
    logic [7:0] d;
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h91, a);
    bus_stop();
    chk("R9 store command ACK", a, 1);
    wait_ready(polls, ok);
    chk("R8 store made busy", polls > 1, 1);
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h01, a);
    send_byte(8'h77, a);
    bus_stop();
    chk("R3 wiper A overwritten", wiper_a, 8'h77);
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h89, a);
    bus_stop();
    tick(10);
    chk("R9 restore into A", wiper_a, 8'h11);
    bus_start();
    send_byte(8'h5A, a);
    send_byte(8'h41, a);
    bus_start();
    send_byte(8'h5B, a);
    recv_byte(d, 1'b1);
    bus_stop();
    chk("R9 stored copy", d, 8'h11);
  endtask

  task automatic t_strap();
    logic a;
    strap = 2'b10;
    tick(5);
    bus_start();
    send_byte(8'h5A, a);
    bus_stop();
    chk("R2 old strap NACK", a, 0);
    bus_start();
    send_byte(8'h5C, a);
    chk("R2 new strap ACK", a, 1);
    send_byte(8'h03, a);
    send_byte(8'h66, a);
    bus_stop();
    chk("R2 write via new strap", wiper_b, 8'h66);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_mismatch();
    t_single();
    t_consec();
    t_unimpl();
    t_random();
    t_current();
    t_nv();
    t_cmd();
    t_strap();
    chk("R10 SDA moved with SCL high", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule